// File: doc/BRIEF.md
# Dual-Channel Cross Correlator Accumulator

This block sits behind the digital I/Q front end of a two-channel microwave radiometer. On every cycle where the input strobe is high, it takes one signed in-phase and one signed quadrature sample from each of the two channels. From these it forms eight fixed products: the self-power terms and the selected cross terms between the channels. Each product is added into its own accumulator. The accumulation window is counted in accepted samples, and its length is set by a parameter; a 0.1 s window at a 32 MHz sample rate is 3,200,000 samples.

When the last sample of a window has been accepted, the eight sums are copied into a holding register, and the accumulators start over with the next accepted sample, so no sample is lost. The held sums then leave the block on one serial line, one word after another. Each word goes MSB first, and a strobe marks the first bit of every word. The next window accumulates while this transfer runs. If a window closes while the previous transfer is still in progress, a sticky overrun flag is raised. The new sums replace the old ones, and the transfer restarts from the first word.

Top module: `xcorr_accum`

## Requirements
- R1: While reset is asserted (rst_n low), and on the cycle after it is released, ser_valid, ser_first, ser_data, period_done and overrun are all 0.
- R2: Word k of a frame carries the sum of the product pair k from this list, for k = 0 to 7: I1·I1, I1·Q2, Q1·Q1, Q1·I2, I2·I2, I2·I1, Q2·Q2, Q2·Q1. Samples and products are signed two's complement.
- R3: Each word is ACC_W = 2·SAMPLE_W + clog2(PERIOD_LEN) bits wide, two's complement. A full window of full-scale products (−32·−32 for 6-bit samples) is held exactly, without overflow.
- R4: A window closes after exactly PERIOD_LEN samples accepted with in_valid high. Inputs present while in_valid is low have no effect on any sum.
- R5: period_done is high for exactly one cycle: the cycle after the clock edge that accepted the last sample of a window. It is low at all other times.
- R6: A frame starts in the same cycle as period_done. ser_valid then stays high for 8·ACC_W consecutive cycles, and each word is sent MSB first. ser_first is high on the first bit of each word and low on every other cycle.
- R7: The sample accepted on the cycle right after a window closes is counted as the first sample of the next window. That window accumulates while the previous frame is being sent.
- R8: overrun becomes 1 when a window closes while a frame is still being sent, other than on its final bit. It then stays 1 until reset. While frames complete before the next window closes, it stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample strobe; the four lanes are accepted on this edge |
| i1 | input | SAMPLE_W | Channel 1 in-phase sample, signed |
| q1 | input | SAMPLE_W | Channel 1 quadrature sample, signed |
| i2 | input | SAMPLE_W | Channel 2 in-phase sample, signed |
| q2 | input | SAMPLE_W | Channel 2 quadrature sample, signed |
| ser_data | output | 1 | Serial result bit |
| ser_valid | output | 1 | High while a frame is being sent |
| ser_first | output | 1 | Marks the first (most significant) bit of each word |
| period_done | output | 1 | One-cycle pulse when a window closes |
| overrun | output | 1 | Sticky flag: a window closed during a transfer |

## Verification
The hardest case to reach is a window closing at the moment the previous frame is still being sent, while no sample is lost across the boundary. The stimulus spaces the samples so that each window lasts a little longer than one frame. It then places the first sample of the following window on the cycle right after the closing sample. Overrun is forced by switching to back-to-back samples, so that a window closes a few words into a transfer.

// File: rtl/xcorr_pkg.sv
package xcorr_pkg;
  localparam int NUM_TERMS = 8;
  localparam int NUM_LANES = 4;

  // lane numbering: 0 = I1, 1 = Q1, 2 = I2, 3 = Q2
  function automatic int term_lane_a(input int k);
    return k / 2;
  endfunction

  function automatic int term_lane_b(input int k);
    case (k)
      0: return 0;
      1: return 3;
      2: return 1;
      3: return 2;
      4: return 2;
      5: return 0;
      6: return 3;
      default: return 1;
    endcase
  endfunction

  // accumulator width that holds a full window of extreme products
  function automatic int acc_width(input int sample_w, input int period_len);
    return 2 * sample_w + $clog2(period_len);
  endfunction
endpackage

// File: rtl/xcorr_period.sv
module xcorr_period #(
  parameter int PERIOD_LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sample_en,
  output logic last_sample,
  output logic period_done
);
  localparam int CNT_W = $clog2(PERIOD_LEN);

  logic [CNT_W-1:0] cnt;

  assign last_sample = sample_en && (cnt == CNT_W'(PERIOD_LEN - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt         <= '0;
      period_done <= 1'b0;
    end else begin
      period_done <= last_sample;
      if (last_sample)    cnt <= '0;
      else if (sample_en) cnt <= cnt + 1'b1;
    end
  end

  // R4: the sample count never passes the window length
  a_r4_count_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(PERIOD_LEN - 1));

  // R5: a close pulse always follows an accepted sample
  a_r5_done_after_sample: assert property (@(posedge clk) disable iff (!rst_n)
    period_done |-> $past(sample_en));

  // R5: never two pulses in a row (window length of at least 2)
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    period_done |=> !period_done);
endmodule

// File: rtl/xcorr_mac.sv
module xcorr_mac #(
  parameter int SAMPLE_W = 6,
  parameter int ACC_W    = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sample_en,
  input  logic                       close,
  input  logic signed [SAMPLE_W-1:0] op_a,
  input  logic signed [SAMPLE_W-1:0] op_b,
  output logic signed [ACC_W-1:0]    closed_sum
);
  localparam int PROD_W = 2 * SAMPLE_W;

  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  prod_ext;
  logic signed [ACC_W-1:0]  acc;
  logic        [ACC_W:0]    wide_sum;

  assign prod       = op_a * op_b;
  assign prod_ext   = {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};
  assign closed_sum = acc + prod_ext;
  assign wide_sum   = {acc[ACC_W-1], acc} + {prod_ext[ACC_W-1], prod_ext};

  always_ff @(posedge clk) begin
    if (!rst_n)         acc <= '0;
    else if (sample_en) acc <= close ? '0 : closed_sum;
  end

  // R3: the running sum never leaves the signed range of ACC_W bits
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en |-> (wide_sum[ACC_W] == wide_sum[ACC_W-1]));

  // R4: with no accepted sample the accumulator holds
  a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_en |=> $stable(acc));
endmodule

// File: rtl/xcorr_serializer.sv
module xcorr_serializer #(
  parameter int ACC_W     = 16,
  parameter int NUM_WORDS = 8
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               load,
  input  logic [NUM_WORDS-1:0][ACC_W-1:0]    words_in,
  output logic                               ser_data,
  output logic                               ser_valid,
  output logic                               ser_first,
  output logic                               overrun
);
  localparam int BIT_W  = $clog2(ACC_W);
  localparam int WIDX_W = $clog2(NUM_WORDS);

  logic [NUM_WORDS-1:0][ACC_W-1:0] hold;
  logic [WIDX_W-1:0] word_idx;
  logic [BIT_W-1:0]  bit_idx;
  logic              busy;
  logic              word_end;
  logic              frame_end;

  assign word_end  = busy && (bit_idx == '0);
  assign frame_end = word_end && (word_idx == WIDX_W'(NUM_WORDS - 1));
  assign ser_valid = busy;
  assign ser_first = busy && (bit_idx == BIT_W'(ACC_W - 1));
  assign ser_data  = busy && hold[word_idx][bit_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold     <= '0;
      word_idx <= '0;
      bit_idx  <= '0;
      busy     <= 1'b0;
      overrun  <= 1'b0;
    end else if (load) begin
      hold     <= words_in;
      word_idx <= '0;
      bit_idx  <= BIT_W'(ACC_W - 1);
      busy     <= 1'b1;
      if (busy && !frame_end) overrun <= 1'b1;
    end else if (busy) begin
      if (frame_end) begin
        busy <= 1'b0;
      end else if (word_end) begin
        word_idx <= word_idx + 1'b1;
        bit_idx  <= BIT_W'(ACC_W - 1);
      end else begin
        bit_idx <= bit_idx - 1'b1;
      end
    end
  end

  // R6: the word marker only appears inside a frame
  a_r6_first_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    ser_first |-> ser_valid);

  // R6: a frame runs to its end unless a new load arrives
  a_r6_no_early_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !frame_end && !load) |=> busy);

  // R8: once raised, overrun stays raised
  a_r8_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
endmodule

// File: rtl/xcorr_accum.sv
module xcorr_accum #(
  parameter int SAMPLE_W   = 6,
  parameter int PERIOD_LEN = 3200000
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic signed [SAMPLE_W-1:0] i1,
  input  logic signed [SAMPLE_W-1:0] q1,
  input  logic signed [SAMPLE_W-1:0] i2,
  input  logic signed [SAMPLE_W-1:0] q2,
  output logic                       ser_data,
  output logic                       ser_valid,
  output logic                       ser_first,
  output logic                       period_done,
  output logic                       overrun
);
  import xcorr_pkg::*;

  localparam int ACC_W = acc_width(SAMPLE_W, PERIOD_LEN);

  logic signed [SAMPLE_W-1:0] lanes [NUM_LANES];
  logic [NUM_TERMS-1:0][ACC_W-1:0] closed_sums;
  logic last_sample;

  assign lanes[0] = i1;
  assign lanes[1] = q1;
  assign lanes[2] = i2;
  assign lanes[3] = q2;

  xcorr_period #(.PERIOD_LEN(PERIOD_LEN)) u_period (
    .clk         (clk),
    .rst_n       (rst_n),
    .sample_en   (in_valid),
    .last_sample (last_sample),
    .period_done (period_done)
  );

  for (genvar k = 0; k < NUM_TERMS; k++) begin : g_term
    localparam int LA = term_lane_a(k);
    localparam int LB = term_lane_b(k);
    logic signed [ACC_W-1:0] sum_k;

    xcorr_mac #(.SAMPLE_W(SAMPLE_W), .ACC_W(ACC_W)) u_mac (
      .clk        (clk),
      .rst_n      (rst_n),
      .sample_en  (in_valid),
      .close      (last_sample),
      .op_a       (lanes[LA]),
      .op_b       (lanes[LB]),
      .closed_sum (sum_k)
    );
    assign closed_sums[k] = sum_k;
  end

  xcorr_serializer #(.ACC_W(ACC_W), .NUM_WORDS(NUM_TERMS)) u_ser (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (last_sample),
    .words_in  (closed_sums),
    .ser_data  (ser_data),
    .ser_valid (ser_valid),
    .ser_first (ser_first),
    .overrun   (overrun)
  );

  // R6: a frame opens with a word marker in the cycle of the close pulse
  a_r6_frame_opens: assert property (@(posedge clk) disable iff (!rst_n)
    period_done |-> (ser_valid && ser_first));

  // R1: no serial activity right after reset release
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    !rst_n |=> (!ser_valid && !period_done && !overrun));
endmodule

// File: tb/xcorr_accum_tb.sv
module xcorr_accum_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SW         = 6;
  localparam int PLEN       = 16;
  localparam int AW         = 2 * SW + $clog2(PLEN);
  localparam int NW         = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic signed [SW-1:0] i1 = '0, q1 = '0, i2 = '0, q2 = '0;
  logic ser_data, ser_valid, ser_first, period_done, overrun;

  always #(CLK_PERIOD/2) clk = ~clk;

  xcorr_accum #(.SAMPLE_W(SW), .PERIOD_LEN(PLEN)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .i1(i1), .q1(q1), .i2(i2), .q2(q2),
    .ser_data(ser_data), .ser_valid(ser_valid), .ser_first(ser_first),
    .period_done(period_done), .overrun(overrun)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;
  bit mon_on   = 1'b1;
  int words_seen = 0;
  logic [AW-1:0] exp_q [$];

  task automatic chk(input string req, input bit ok, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // lane values per pattern; lane 0=I1 1=Q1 2=I2 3=Q2
  function automatic int lane_val(input int mode, input int s, input int lane);
    case (mode)
      0: return s - 8 + lane;
      1: return -32;
      2: return (lane == 0 || lane == 3) ? -32 : 31;
      default: return ((s * 7 + lane * 13 + 5) % 64) - 32;
    endcase
  endfunction

  // product pairs in word order (R2)
  function automatic int pair_a(input int k);
    int t [8] = '{0, 0, 1, 1, 2, 2, 3, 3};
    return t[k];
  endfunction
  function automatic int pair_b(input int k);
    int t [8] = '{0, 3, 1, 2, 2, 0, 3, 1};
    return t[k];
  endfunction

  // driver: gap idle cycles with junk data before every sample but the first
  task automatic drive_window(input int mode, input int gap, input bit push);
    longint sums [8];
    for (int k = 0; k < 8; k++) sums[k] = 0;
    for (int s = 0; s < PLEN; s++) begin
      if (s != 0) begin
        for (int g = 0; g < gap; g++) begin
          in_valid = 1'b0;
          i1 = 6'sd31; q1 = -6'sd32; i2 = 6'sd17; q2 = -6'sd9; // ignored (R4)
          @(negedge clk);
          chk("R5 no pulse mid-window", period_done == 1'b0, period_done, 0);
        end
      end
      begin
        int v [4];
        for (int l = 0; l < 4; l++) v[l] = lane_val(mode, s, l);
        i1 = SW'(v[0]); q1 = SW'(v[1]); i2 = SW'(v[2]); q2 = SW'(v[3]);
        in_valid = 1'b1;
        for (int k = 0; k < 8; k++) sums[k] += longint'(v[pair_a(k)] * v[pair_b(k)]);
      end
      @(negedge clk);
      if (s == PLEN - 1) begin
        chk("R5 pulse after last sample", period_done == 1'b1, period_done, 1);
        chk("R6 frame starts with pulse", ser_valid && ser_first, ser_valid, 1);
        if (push) for (int k = 0; k < 8; k++) exp_q.push_back(AW'(sums[k]));
      end else begin
        chk("R5 no pulse mid-window", period_done == 1'b0, period_done, 0);
      end
    end
    in_valid = 1'b0;
  endtask

  // monitor: assemble serial words and compare with the scoreboard
  int bit_cnt = 0;
  logic [AW-1:0] shreg = '0;
  always @(negedge clk) begin
    if (!mon_on) begin
      bit_cnt = 0;
    end else if (ser_valid) begin
      chk("R6 word marker position", ser_first == (bit_cnt == 0), ser_first, bit_cnt == 0);
      shreg = {shreg[AW-2:0], ser_data};
      if (bit_cnt == AW - 1) begin
        bit_cnt = 0;
        if (exp_q.size() == 0) begin
          chk("R2 unexpected word", 1'b0, shreg, 0);
        end else begin
          logic [AW-1:0] e;
          e = exp_q.pop_front();
          chk($sformatf("R2/R3/R7 word %0d", words_seen % NW),
              shreg == e, longint'(signed'(shreg)), longint'(signed'(e)));
        end
        words_seen++;
      end else begin
        bit_cnt++;
      end
    end else begin
      if (bit_cnt != 0) chk("R6 frame cut short", 1'b0, bit_cnt, 0);
      bit_cnt = 0;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {ser_valid, ser_first, ser_data, period_done, overrun} == 5'b0,
        {ser_valid, ser_first, ser_data, period_done, overrun}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {ser_valid, period_done, overrun} == 3'b0,
        {ser_valid, period_done, overrun}, 0);

    // windows chained back to back, each a bit longer than one frame (R7)
    drive_window(0, 9, 1'b1);
    drive_window(1, 9, 1'b1); // full-scale products (R3)
    drive_window(2, 9, 1'b1); // mixed signs
    drive_window(3, 9, 1'b1);
    repeat (NW * AW + 20) @(negedge clk);
    chk("R6 all words sent", words_seen == 4 * NW, words_seen, 4 * NW);
    chk("R2 scoreboard drained", exp_q.size() == 0, exp_q.size(), 0);
    chk("R8 no overrun when frames fit", overrun == 1'b0, overrun, 0);

    // R8: back-to-back samples close a window mid-frame
    mon_on = 1'b0;
    drive_window(0, 0, 1'b0);
    chk("R8 first close no overrun", overrun == 1'b0, overrun, 0);
    drive_window(3, 0, 1'b0);
    chk("R8 overrun raised", overrun == 1'b1, overrun, 1);
    repeat (NW * AW + 20) @(negedge clk);
    chk("R8 overrun sticky", overrun == 1'b1, overrun, 1);
    chk("R6 frame finished", ser_valid == 1'b0, ser_valid, 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule